// File: doc/BRIEF.md
# Asynchronous Byte SRAM Controller

This block lets logic on a single system clock read and write an external asynchronous static RAM that is one byte wide and has 20 address bits. The host raises a request with a read/write select, an address and, for writes, a data byte. The controller acknowledges with a one-cycle pulse when it takes the request. It then runs the memory strobes, which are active-low chip enable, output enable and write enable, for a number of clock cycles worked out from nanosecond timing limits. For a read it returns the byte with a one-cycle valid pulse.

All strobe widths are whole clock cycles. Each one is the ceiling of a nanosecond limit divided by the clock period, so moving to another clock or another memory speed grade only means changing parameters. Write enable alone times the write. Output enable stays high for the whole write, so the memory never drives the bus during one. The data pins go out as a separate output value, an output-enable and an input value, and a pad cell at chip level joins them into one bus. After a read the controller waits a set number of cycles before it drives the bus, because the memory may go on driving it for a while after output enable is released.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, with no request, sram_ce_n, sram_oe_n and sram_we_n are 1, and sram_dq_oe, host_ack and host_rvalid are 0.
- R2: host_ack is high for exactly one cycle, in the cycle after the edge at which an idle controller samples host_req high. It stays low for the rest of that access.
- R3: Address and write byte are registered at acceptance. sram_addr does not change while sram_ce_n is low, and changes made to host_addr or host_wdata after the acknowledge have no effect on the access.
- R4: For a read (host_wr=0), sram_ce_n and sram_oe_n go low at acceptance with sram_we_n high. Read data is sampled from sram_dq_i at the edge that ends N_RD cycles. host_rvalid is high for one cycle, N_RD cycles after the acknowledge cycle, with host_rdata holding that byte. sram_oe_n and sram_ce_n return to 1 at the same edge.
- R5: For a write (host_wr=1), sram_oe_n stays 1 throughout. When no turnaround is pending, sram_we_n falls one cycle after acceptance, and it stays low for exactly N_WP cycles.
- R6: During a write, sram_dq_oe is 1 from the fall of sram_we_n until sram_ce_n is released, and sram_dq_o holds the accepted byte for that whole time. This puts the data on the bus at least the data-setup time before sram_we_n rises.
- R7: sram_we_n rises one cycle before sram_ce_n rises, and therefore one cycle before the address may change.
- R8: After a read releases output enable, sram_dq_oe stays 0 for at least N_HZ cycles. A write accepted in the cycle right after a read completes has its write-enable fall max(1, N_HZ) cycles after acceptance.
- R9: sram_dq_oe is never 1 while sram_oe_n is 0.
- R10: The cycle counts are ceiling divisions by CLK_NS:
  - N_RD = max(ceil(T_AA), ceil(T_RC)).
  - N_WP = max(ceil(T_WP), ceil(T_DW), ceil(T_AW)-1, ceil(T_CW)-1).
  - N_HZ = ceil(T_HZ) + TURN_EXTRA.
  - Elaboration fails if any of them is below 1.
  - At 8 ns with the 55 ns grade they are 7, 6 and 4.
- R11: A byte written to any address, including 0x00000 and 0xFFFFF, is returned by a later read of that address. A second write to the same address replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_ack | output | 1 | One-cycle pulse when the request is taken |
| host_rdata | output | 8 | Byte returned by a read |
| host_rvalid | output | 1 | One-cycle pulse, host_rdata valid |
| sram_addr | output | 20 | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Pad drive enable for sram_dq_o |
| sram_dq_i | input | 8 | Data sampled from the memory bus |

## Verification
Writes and reads are tried from idle, back to back, at the lowest and highest address, as an overwrite of one address, and at random addresses. Random addresses separate address-bit faults from data faults. The overwrite case separates a stale byte from a fresh one. A write issued in the cycle right after a read shows whether the turnaround wait is taken, as against a write from idle, which shows the one-cycle setup alone. The behavioural memory timestamps every strobe and bus edge in nanoseconds and counts breaches of the access, pulse-width, setup and bus-release limits. The host is allowed to scramble its inputs right after the acknowledge, so that capture at acceptance is told apart from a live pass-through.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } seq_st_e;

  // cycles needed to cover ns_val at a clock period of clk_ns
  function automatic int ceil_div(input int ns_val, input int clk_ns);
    return (ns_val + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
`timescale 1ns/1ps
module sram_ctl_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  p_cnt_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  input  logic ph_zero,
  input  logic hz_zero,
  output logic accept,
  output logic rd_fin,
  output logic we_start,
  output logic ack,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);
  seq_st_e st_q;

  // named events, shared by datapath, counters and assertions
  assign accept   = (st_q == ST_IDLE) && req;
  assign rd_fin   = (st_q == ST_RD) && ph_zero;
  assign we_start = (st_q == ST_WSET) && hz_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack   <= 1'b0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ack <= accept;
      unique case (st_q)
        ST_IDLE: if (req) begin
          ce_n <= 1'b0;
          if (wr) st_q <= ST_WSET;
          else begin
            oe_n <= 1'b0;
            st_q <= ST_RD;
          end
        end
        ST_RD: if (ph_zero) begin
          oe_n <= 1'b1;
          ce_n <= 1'b1;
          st_q <= ST_IDLE;
        end
        ST_WSET: if (hz_zero) begin
          we_n  <= 1'b0;
          dq_oe <= 1'b1;
          st_q  <= ST_WPUL;
        end
        ST_WPUL: if (ph_zero) begin
          we_n <= 1'b1;
          st_q <= ST_WREC;
        end
        ST_WREC: begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_we_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));
  p_we_before_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(we_n));
  p_no_drive_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  p_read_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));
endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_fin,
  input  logic          ce_n,
  input  logic          dq_oe,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      if (accept) begin
        mem_addr  <= host_addr;
        mem_wdata <= host_wdata;
      end
      if (rd_fin) rdata <= dq_i;
      rvalid <= rd_fin;
    end
  end

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(mem_wdata));
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int CLK_NS     = 8,
  parameter int T_RC_NS    = 55,
  parameter int T_AA_NS    = 55,
  parameter int T_WP_NS    = 45,
  parameter int T_DW_NS    = 25,
  parameter int T_AW_NS    = 50,
  parameter int T_CW_NS    = 50,
  parameter int T_HZ_NS    = 25,
  parameter int TURN_EXTRA = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int N_RD = max2(ceil_div(T_AA_NS, CLK_NS), ceil_div(T_RC_NS, CLK_NS));
  localparam int N_WP = max2(max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DW_NS, CLK_NS)),
                             max2(ceil_div(T_AW_NS, CLK_NS) - 1, ceil_div(T_CW_NS, CLK_NS) - 1));
  localparam int N_HZ = ceil_div(T_HZ_NS, CLK_NS) + TURN_EXTRA;
  localparam int PH_W = cnt_width(max2(N_RD, N_WP));
  localparam int HZ_W = cnt_width(N_HZ);
  localparam logic [PH_W-1:0] RD_LOAD = PH_W'(N_RD - 1);
  localparam logic [PH_W-1:0] WP_LOAD = PH_W'(N_WP - 1);
  localparam logic [HZ_W-1:0] HZ_LOAD = HZ_W'(N_HZ);

  generate
    if (N_RD < 1 || N_WP < 1 || N_HZ < 1) begin : g_bad_counts
      $error("sram_ctl: a derived strobe count is below one cycle");
    end
  endgenerate

  logic accept, rd_fin, we_start, ph_zero, hz_zero;
  logic            ph_load;
  logic [PH_W-1:0] ph_val;

  assign ph_load = (accept && !host_wr) || we_start;
  assign ph_val  = we_start ? WP_LOAD : RD_LOAD;

  sram_ctl_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (host_req),
    .wr       (host_wr),
    .ph_zero  (ph_zero),
    .hz_zero  (hz_zero),
    .accept   (accept),
    .rd_fin   (rd_fin),
    .we_start (we_start),
    .ack      (host_ack),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe)
  );

  // phase counter: read access wait, then write pulse width
  sram_ctl_cnt #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .dec      (1'b1),
    .zero     (ph_zero)
  );

  // turnaround counter: started when a read releases the bus
  sram_ctl_cnt #(.W(HZ_W)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_fin),
    .load_val (HZ_LOAD),
    .dec      (1'b1),
    .zero     (hz_zero)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_fin     (rd_fin),
    .ce_n       (sram_ce_n),
    .dq_oe      (sram_dq_oe),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .dq_i       (sram_dq_i),
    .mem_addr   (sram_addr),
    .mem_wdata  (sram_dq_o),
    .rdata      (host_rdata),
    .rvalid     (host_rvalid)
  );

  // cycles since output enable was last low, saturating at N_HZ
  logic [HZ_W-1:0] since_oe;
  always_ff @(posedge clk) begin
    if (!rst_n)                since_oe <= HZ_LOAD;
    else if (!sram_oe_n)       since_oe <= '0;
    else if (since_oe < HZ_LOAD) since_oe <= since_oe + 1'b1;
  end

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_oe >= HZ_LOAD));
  p_we_fall_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_ce_n));
endmodule

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [19:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack, host_rvalid;
  logic [7:0]  host_rdata;
  logic [19:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_o, sram_dq_i;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // expected counts: smallest n with n*8 >= limit
  function automatic int need(input int ns_lim);
    int n = 0;
    while (n * 8 < ns_lim) n++;
    return n;
  endfunction
  localparam int E_RD = 7;
  localparam int E_WP = 6;
  localparam int E_HZ = 4;

  // ---------------- behavioural memory with timing monitor ----------------
  logic [7:0] mem_arr [logic [19:0]];
  real t_addr = -1000.0, t_ce_fall = -1000.0, t_we_fall = -1000.0;
  real t_dq = -1000.0, t_oe_rise = -1000.0;
  int viol_wr = 0, viol_cyc = 0, viol_bus = 0, viol_rd = 0;

  function automatic logic [7:0] rd_lookup(input logic [19:0] a);
    if (mem_arr.exists(a)) return mem_arr[a];
    return 8'h00;
  endfunction

  assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n) ? rd_lookup(sram_addr) : 8'h00;

  always @(sram_addr) begin
    if (rst_n) begin
      if (!sram_we_n) viol_wr++;
      if ($realtime - t_addr < 55.0) viol_cyc++;
    end
    t_addr = $realtime;
  end
  always @(negedge sram_ce_n) t_ce_fall = $realtime;
  always @(negedge sram_we_n) t_we_fall = $realtime;
  always @(posedge sram_oe_n) t_oe_rise = $realtime;
  always @(sram_dq_o or sram_dq_oe) t_dq = $realtime;
  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n) begin
      if ($realtime - t_we_fall < 45.0) viol_wr++;
      if ($realtime - t_ce_fall < 50.0) viol_wr++;
      if ($realtime - t_addr < 50.0) viol_wr++;
      if ($realtime - t_dq < 25.0) viol_wr++;
      if (!sram_dq_oe) viol_wr++;
      mem_arr[sram_addr] = sram_dq_o;
    end
  end
  always @(posedge sram_dq_oe) begin
    if (rst_n) begin
      if (!sram_oe_n) viol_bus++;
      if ($realtime - t_oe_rise < 25.0) viol_bus++;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic take_req(input bit wr, input logic [19:0] a, input logic [7:0] d);
    int guard = 0;
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    while (!host_ack && guard < 50) begin @(negedge clk); guard++; end
    chk("R2 ack seen", int'(host_ack), 1);
    chk("R3 addr at accept", int'(sram_addr), int'(a));
    host_req = 1'b0; host_addr = ~a; host_wdata = ~d;  // later changes must be ignored
  endtask

  task automatic run_write(input logic [19:0] a, input logic [7:0] d, output int t_we,
                           output int n_we, output int t_off);
    int bad_local = 0;
    take_req(1'b1, a, d);
    t_we = -1; n_we = 0; t_off = -1;
    for (int k = 1; k < 40; k++) begin
      @(negedge clk);
      if (host_ack || !sram_oe_n) bad_local++;
      if (!sram_ce_n && sram_addr != a) bad_local++;
      if (!sram_we_n) begin
        if (t_we < 0) t_we = k;
        n_we++;
        if (!sram_dq_oe || sram_dq_o != d) bad_local++;
      end
      if (sram_ce_n) begin t_off = k; break; end
    end
    chk("R2/R3/R5/R6 write cycle errors", bad_local, 0);
  endtask

  task automatic run_read(input logic [19:0] a, output logic [7:0] q, output int t_val);
    int bad_local = 0;
    real t_cap;
    take_req(1'b0, a, 8'h00);
    chk("R4 oe low at accept", int'(sram_oe_n), 0);
    t_val = -1; q = 8'h00;
    for (int k = 1; k < 40; k++) begin
      @(negedge clk);
      if (host_ack || sram_dq_oe || !sram_we_n) bad_local++;
      if (sram_dq_oe && !sram_oe_n) bad_local++;  // R9
      if (host_rvalid) begin
        t_val = k; q = host_rdata;
        t_cap = $realtime - 4.0;
        if (t_cap - ((t_addr > t_ce_fall) ? t_addr : t_ce_fall) < 55.0) viol_rd++;
        if (!sram_oe_n || !sram_ce_n) bad_local++;
        break;
      end
      if (sram_oe_n || sram_ce_n) bad_local++;
    end
    chk("R4/R9 read cycle errors", bad_local, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    chk("R1 ce_n in reset", int'(sram_ce_n), 1);
    chk("R1 dq_oe in reset", int'(sram_dq_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 strobes idle", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
    chk("R1 ack/rvalid idle", int'({host_ack, host_rvalid}), 0);
  endtask

  task automatic t_counts;
    chk("R10 read count", need(55), E_RD);
    chk("R10 pulse count", need(50) - 1 > need(45) ? need(50) - 1 : need(45), E_WP);
    chk("R10 turnaround count", need(25), E_HZ);
  endtask

  task automatic t_write_then_read;
    int tw, nw, toff, tv;
    logic [7:0] q;
    run_write(20'h00000, 8'h3C, tw, nw, toff);
    chk("R5 we fall from idle", tw, 1);
    chk("R5 we low width", nw, E_WP);
    chk("R7 ce release after we rise", toff, tw + E_WP + 1);
    repeat (2) @(negedge clk);
    run_read(20'h00000, q, tv);
    chk("R4 R10 rvalid delay", tv, E_RD);
    chk("R11 data at 0x00000", int'(q), 8'h3C);
    @(negedge clk);
    chk("R4 rvalid single cycle", int'(host_rvalid), 0);
  endtask

  task automatic t_turnaround;
    int tw, nw, toff, tv;
    logic [7:0] q;
    run_read(20'h00000, q, tv);
    run_write(20'h00001, 8'h5A, tw, nw, toff);   // accepted the cycle after rvalid
    chk("R8 we fall after read", tw, (E_HZ > 1) ? E_HZ : 1);
    chk("R6 width after turnaround", nw, E_WP);
    run_write(20'h00002, 8'hA5, tw, nw, toff);   // write after write: no wait
    chk("R5 we fall after write", tw, 1);
    run_read(20'h00001, q, tv);
    chk("R11 data after turnaround", int'(q), 8'h5A);
  endtask

  task automatic t_edges;
    int tw, nw, toff, tv;
    logic [7:0] q;
    run_write(20'hFFFFF, 8'hFF, tw, nw, toff);
    run_write(20'h7FFFF, 8'h01, tw, nw, toff);
    run_write(20'h80000, 8'h80, tw, nw, toff);
    run_read(20'hFFFFF, q, tv);
    chk("R11 data at 0xFFFFF", int'(q), 8'hFF);
    run_read(20'h7FFFF, q, tv);
    chk("R11 data at 0x7FFFF", int'(q), 8'h01);
    run_read(20'h80000, q, tv);
    chk("R11 data at 0x80000", int'(q), 8'h80);
    run_write(20'h80000, 8'h6E, tw, nw, toff);
    run_read(20'h80000, q, tv);
    chk("R11 overwrite", int'(q), 8'h6E);
  endtask

  task automatic t_random;
    logic [7:0]  sb [logic [19:0]];
    logic [19:0] al [24];
    int tw, nw, toff, tv, errs = 0;
    logic [7:0] q;
    for (int i = 0; i < 24; i++) begin
      al[i] = 20'($urandom);
      sb[al[i]] = 8'($urandom);
      run_write(al[i], sb[al[i]], tw, nw, toff);
    end
    for (int i = 0; i < 24; i++) begin
      run_read(al[i], q, tv);
      if (q != sb[al[i]]) begin
        errs++;
        $display("FAIL R11 addr=%h actual=%h expected=%h", al[i], q, sb[al[i]]);
      end
    end
    chk("R11 random readback mismatches", errs, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_counts();
    t_write_then_read();
    t_turnaround();
    t_edges();
    t_random();
    repeat (4) @(negedge clk);
    chk("R4 read access time breaches", viol_rd, 0);
    chk("R5 R6 write timing breaches", viol_wr, 0);
    chk("R3 address cycle breaches", viol_cyc, 0);
    chk("R8 R9 bus contention", viol_bus, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule